// File: doc/BRIEF.md
# Channel-Interleaved PCM Bus Slot Controller

This block lets one 2.048 Mb/s framer port share a faster serial backplane bus with other ports. A frame holds 32 byte-wide channels. On the shared bus, channel k of every port is sent in turn, one whole byte per port. Channel k+1 starts only after every port has sent channel k. The block reads bytes from an already-filled receive elastic buffer through a valid/ready port. It shifts each byte out MSB first, and it drives the bus only during the byte slot it owns.

A speed code sets how many ports share the bus: 2, 4 or 8. A position code picks which slot in each channel round belongs to this port. While interleaving is enabled, the block is the frame timing master: it generates the frame sync and ignores the external one. While interleaving is disabled, it runs as a plain single stream that realigns on the external frame sync. A clock-source bit is registered and brought out as a selector for the transmit clock.

Byte port rules: `rd_ready` is high for exactly one bus clock, the one just before each owned slot. A byte is taken on that clock edge when `rd_valid` is also high. `rd_valid` never stalls the bus. If no byte is offered when `rd_ready` is high, the slot carries the idle byte 0xFF. Configuration inputs are quasi-static and should only change while reset is asserted.

Top module: `pcm_slot_ctrl`

## Requirements
- R1: After reset, the frame lasts 256·N bus clocks. N is 2, 4 or 8 for speed codes 0, 1 and 2 when interleaving is enabled, and N is 1 when it is disabled. `fsync_out` is high for the single clock in which the bit counter is 0, starting with the first clock after reset release.
- R2: In interleaved mode without error, `ser_oe` is high exactly in bus clocks whose bit count c satisfies floor(c/8) mod N = position. That is 8 consecutive clocks per channel round. During reset `ser_oe` is low.
- R3: During an owned slot, `ser_data` carries the accepted byte MSB first, one bit per bus clock.
- R4: `rd_ready` is high exactly in the clock before each owned slot starts. It is never high during reset.
- R5: If `rd_valid` is low while `rd_ready` is high, the following slot sends 0xFF.
- R6: With interleaving enabled, a position of N or above, or the reserved speed code 3, raises `cfg_err` and keeps `ser_oe` and `rd_ready` low.
- R7: With interleaving enabled and `buf_enabled` low, `cfg_err` is high and `ser_oe` and `rd_ready` stay low.
- R8: With interleaving disabled, `cfg_err` is low whatever the position and buffer flag. `ser_oe` is high on every clock from the first clock after reset release.
- R9: With interleaving disabled, a high `fsync_in` at a clock edge makes the next clock bit 0 of a new frame. With interleaving enabled, `fsync_in` has no effect.
- R10: `txclk_sys` is 0 in reset and otherwise equals `cfg_clk_src` as sampled on the previous edge (1 = derive transmit clock from the system clock, 0 = dedicated transmit clock input).
- R11: `ser_data` is 0 whenever `ser_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1 = interleaved bus mode |
| cfg_speed | input | 2 | 0: 2 ports, 1: 4 ports, 2: 8 ports, 3: reserved |
| cfg_pos | input | 3 | Slot position of this port in each channel round |
| cfg_clk_src | input | 1 | Transmit clock source select |
| buf_enabled | input | 1 | Elastic buffer enabled flag |
| fsync_in | input | 1 | External frame sync (single mode only) |
| rd_valid | input | 1 | Elastic buffer byte available |
| rd_data | input | 8 | Elastic buffer byte |
| rd_ready | output | 1 | Byte taken on this edge if valid |
| ser_data | output | 1 | Serial bus data |
| ser_oe | output | 1 | Bus drive enable / data valid |
| fsync_out | output | 1 | Generated frame sync |
| cfg_err | output | 1 | Illegal configuration |
| txclk_sys | output | 1 | Registered transmit clock source select |

## Verification
The hardest case to reach is an external frame sync that arrives in the middle of a byte in single mode. That cuts the byte short, and a new load must happen on the same edge. A second hard case is an underrun that lands exactly on the one clock when `rd_ready` is high. The bench creates both with random stimulus from a fixed seed. Frame syncs are pulsed with low probability on every clock, and `rd_valid` is dropped about one time in five. An independent counter model then predicts which byte, or the idle byte, each slot must carry. Directed runs cover the highest position at eight ports, an out-of-range position, the reserved speed code and a disabled buffer.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic [1:0] {
    SPD_TWO   = 2'd0,
    SPD_FOUR  = 2'd1,
    SPD_EIGHT = 2'd2,
    SPD_RSVD  = 2'd3
  } bus_speed_e;

  // log2 of the number of ports sharing the bus, capped at the maximum
  function automatic int speed_log2(input logic [1:0] code, input int max_log2);
    int s;
    s = int'(code) + 1;
    if (s > max_log2) s = max_log2;
    return s;
  endfunction
endpackage

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
  parameter int CNT_W   = 11,
  parameter int BYTE_SH = 3,
  parameter int DEV_SH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               realign_en,
  input  logic               fsync_in,
  input  logic [CNT_W-1:0]   frame_last,
  output logic               running,
  output logic               fsync_out,
  output logic [DEV_SH-1:0]  cur_dev,
  output logic [BYTE_SH-1:0] cur_bit,
  output logic [DEV_SH-1:0]  nxt_dev,
  output logic [BYTE_SH-1:0] nxt_bit
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             run_q;

  always_comb begin
    if (!run_q)                    cnt_nxt = '0;
    else if (realign_en && fsync_in) cnt_nxt = '0;
    else if (cnt_q >= frame_last)  cnt_nxt = '0;
    else                           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      run_q <= 1'b1;
    end
  end

  assign running   = run_q;
  assign fsync_out = run_q && (cnt_q == '0);
  assign cur_bit   = cnt_q[BYTE_SH-1:0];
  assign cur_dev   = cnt_q[BYTE_SH +: DEV_SH];
  assign nxt_bit   = cnt_nxt[BYTE_SH-1:0];
  assign nxt_dev   = cnt_nxt[BYTE_SH +: DEV_SH];

  // R1: a frame is far longer than one clock, so sync never repeats back to back
  assert_fsync_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_out && !realign_en) |=> !fsync_out);
endmodule

// File: rtl/pcm_slot_decode.sv
module pcm_slot_decode
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int BYTE_SH = 3,
  parameter int DEV_SH  = 3
) (
  input  logic               enable,
  input  logic [1:0]         speed,
  input  logic [DEV_SH-1:0]  pos,
  input  logic               buf_ok,
  input  logic [DEV_SH-1:0]  cur_dev,
  input  logic [DEV_SH-1:0]  nxt_dev,
  input  logic [BYTE_SH-1:0] nxt_bit,
  output logic [CNT_W-1:0]   frame_last,
  output logic               cfg_err,
  output logic               own_now,
  output logic               load_now
);
  logic [DEV_SH-1:0] mask;
  int                sh;

  always_comb begin
    sh         = enable ? speed_log2(speed, DEV_SH) : 0;
    mask       = DEV_SH'((1 << sh) - 1);
    frame_last = {CNT_W{1'b1}} >> (DEV_SH - sh);
    cfg_err    = enable && (!buf_ok || (bus_speed_e'(speed) == SPD_RSVD) ||
                            ((pos & ~mask) != '0));
    own_now    = !enable || ((cur_dev & mask) == pos);
    load_now   = (nxt_bit == '0) && (!enable || ((nxt_dev & mask) == pos));
  end
endmodule

// File: rtl/pcm_byte_shifter.sv
module pcm_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic              msb
);
  localparam logic [BYTE_W-1:0] IDLE = '1;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh_q <= IDLE;
    else if (load) sh_q <= take ? din : IDLE;
    else           sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
  end

  assign msb = sh_q[BYTE_W-1];
endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl #(
  parameter int CHANNELS = 32,
  parameter int BYTE_W   = 8,
  parameter int MAX_DEV  = 8,
  localparam int BYTE_SH = $clog2(BYTE_W),
  localparam int DEV_SH  = $clog2(MAX_DEV),
  localparam int CNT_W   = $clog2(CHANNELS) + BYTE_SH + DEV_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_speed,
  input  logic [DEV_SH-1:0] cfg_pos,
  input  logic              cfg_clk_src,
  input  logic              buf_enabled,
  input  logic              fsync_in,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              ser_data,
  output logic              ser_oe,
  output logic              fsync_out,
  output logic              cfg_err,
  output logic              txclk_sys
);
  logic               running, own_now, load_now, shift_msb;
  logic [CNT_W-1:0]   frame_last;
  logic [DEV_SH-1:0]  cur_dev, nxt_dev;
  logic [BYTE_SH-1:0] cur_bit, nxt_bit;
  logic               clk_sel_q;

  pcm_bit_timer #(.CNT_W(CNT_W), .BYTE_SH(BYTE_SH), .DEV_SH(DEV_SH)) u_timer (
    .clk(clk), .rst_n(rst_n), .realign_en(!cfg_enable), .fsync_in(fsync_in),
    .frame_last(frame_last), .running(running), .fsync_out(fsync_out),
    .cur_dev(cur_dev), .cur_bit(cur_bit), .nxt_dev(nxt_dev), .nxt_bit(nxt_bit)
  );

  pcm_slot_decode #(.CNT_W(CNT_W), .BYTE_SH(BYTE_SH), .DEV_SH(DEV_SH)) u_decode (
    .enable(cfg_enable), .speed(cfg_speed), .pos(cfg_pos), .buf_ok(buf_enabled),
    .cur_dev(cur_dev), .nxt_dev(nxt_dev), .nxt_bit(nxt_bit),
    .frame_last(frame_last), .cfg_err(cfg_err), .own_now(own_now), .load_now(load_now)
  );

  assign rd_ready = rst_n && load_now && !cfg_err;
  assign ser_oe   = running && own_now && !cfg_err;

  pcm_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(rd_ready), .take(rd_valid),
    .din(rd_data), .msb(shift_msb)
  );

  assign ser_data = ser_oe && shift_msb;

  always_ff @(posedge clk) begin
    if (!rst_n) clk_sel_q <= 1'b0;
    else        clk_sel_q <= cfg_clk_src;
  end
  assign txclk_sys = clk_sel_q;

  // Fields of the bit position that only matter for the bit index
  logic unused_bits;
  assign unused_bits = ^cur_bit;

  // R4: a granted byte is always followed by the owned slot
  assert_ready_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> ser_oe);
  // R3: the bus is never entered without a byte load on the edge before
  assert_load_before_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> $past(rd_ready));
  // R6: a bad configuration never requests data from the buffer
  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!rd_ready && !ser_oe));
  // R11: the data line is quiet outside the slot
  assert_idle_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_data);
endmodule

// File: tb/test_pcm_slot_ctrl.sv
`timescale 1ns/1ps
module test_pcm_slot_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_clk_src = 1'b0, buf_enabled = 1'b0;
  logic [1:0] cfg_speed = 2'd0;
  logic [2:0] cfg_pos = 3'd0;
  logic       fsync_in = 1'b0, rd_valid = 1'b0;
  logic [7:0] rd_data = 8'd0;
  logic       rd_ready, ser_data, ser_oe, fsync_out, cfg_err, txclk_sys;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pcm_slot_ctrl i_pcm_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_speed(cfg_speed),
    .cfg_pos(cfg_pos), .cfg_clk_src(cfg_clk_src), .buf_enabled(buf_enabled),
    .fsync_in(fsync_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .ser_data(ser_data), .ser_oe(ser_oe),
    .fsync_out(fsync_out), .cfg_err(cfg_err), .txclk_sys(txclk_sys)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ports_for(input logic en, input logic [1:0] spd);
    if (!en) return 1;
    case (spd)
      2'd0: return 2;
      2'd1: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic owns(input logic en, input int c, input int n, input int pos);
    return !en || (((c / 8) % n) == pos);
  endfunction

  task automatic run_case(input logic en, input logic [1:0] spd, input logic [2:0] pos,
                          input logic bok, input logic csrc, input int frames,
                          input int sync_rate);
    int n, last, m, m_n;
    logic started, err, exp_oe, exp_d, exp_rdy, fs, cur_idle, pend_idle;
    logic [7:0] cur, pend;
    string err_tag;
    rst_n = 1'b0;
    cfg_enable = en; cfg_speed = spd; cfg_pos = pos;
    buf_enabled = bok; cfg_clk_src = csrc;
    fsync_in = 1'b0; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset oe", {7'd0, ser_oe}, 8'd0);
    chk("R4 reset ready", {7'd0, rd_ready}, 8'd0);
    chk("R1 reset sync", {7'd0, fsync_out}, 8'd0);
    chk("R10 reset clk sel", {7'd0, txclk_sys}, 8'd0);
    rst_n = 1'b1;
    n = ports_for(en, spd);
    if (en && spd == 2'd3) n = 8;
    last = 256 * n - 1;
    err = en && (!bok || spd == 2'd3 || int'(pos) >= n);
    err_tag = !en ? "R8" : (!bok ? "R7" : "R6");
    started = 1'b0; m = 0; pend = 8'hFF; pend_idle = 1'b1; cur = 8'hFF; cur_idle = 1'b1;
    for (int k = 0; k < frames * (last + 1) + 2; k++) begin
      fs = (sync_rate != 0) && ($urandom_range(sync_rate - 1) == 0);
      fsync_in = fs;
      rd_valid = ($urandom_range(9) < 8);
      rd_data = 8'($urandom);
      #1;
      exp_oe = started && owns(en, m, n, pos) && !err;
      if (exp_oe && (m % 8) == 0) begin
        cur = pend; cur_idle = pend_idle;
      end
      exp_d = exp_oe ? cur[7 - (m % 8)] : 1'b0;
      m_n = (!started || (!en && fs)) ? 0 : ((m == last) ? 0 : m + 1);
      exp_rdy = !err && ((m_n % 8) == 0) && owns(en, m_n, n, pos);
      chk(en ? "R2 oe" : "R8 oe", {7'd0, ser_oe}, {7'd0, exp_oe});
      if (exp_oe) chk(cur_idle ? "R5 idle byte" : "R3 data", {7'd0, ser_data}, {7'd0, exp_d});
      else        chk("R11 quiet line", {7'd0, ser_data}, 8'd0);
      chk("R4 ready", {7'd0, rd_ready}, {7'd0, exp_rdy});
      chk(sync_rate != 0 ? "R9 frame sync" : "R1 frame sync",
          {7'd0, fsync_out}, {7'd0, started && m == 0});
      chk(err_tag, {7'd0, cfg_err}, {7'd0, err});
      chk("R10 clk sel", {7'd0, txclk_sys}, {7'd0, started && csrc});
      if (exp_rdy) begin
        pend = rd_valid ? rd_data : 8'hFF;
        pend_idle = !rd_valid;
      end
      m = m_n;
      started = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R8 and R9: single stream, stray position and buffer flag, random resyncs
    run_case(1'b0, 2'd2, 3'd5, 1'b0, 1'b0, 2, 300);
    run_case(1'b1, 2'd0, 3'd1, 1'b1, 1'b1, 2, 0);
    run_case(1'b1, 2'd1, 3'd3, 1'b1, 1'b0, 2, 0);
    // R9: external sync ignored while interleaving
    run_case(1'b1, 2'd2, 3'd0, 1'b1, 1'b1, 2, 200);
    run_case(1'b1, 2'd2, 3'd7, 1'b1, 1'b0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(2));
      run_case(1'b1, s, 3'($urandom_range(ports_for(1'b1, s) - 1)), 1'b1,
               1'($urandom), 1, 0);
    end
    // R6: position out of range, reserved speed; R7: buffer not enabled
    run_case(1'b1, 2'd0, 3'd2, 1'b1, 1'b0, 1, 0);
    run_case(1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 1, 0);
    run_case(1'b1, 2'd1, 3'd1, 1'b0, 1'b1, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule